// File: doc/BRIEF.md
# Trap Cause and Value Register Bank

This block keeps the state a core records when it takes a trap. That state is three registers for each of two privilege levels, machine and supervisor: the trap return PC, the cause, and the trap value. The core reports a trap with a one-cycle strobe. The strobe carries the destination level, an interrupt flag, a 4-bit cause code, the PC of the trapping instruction, and an information word. The information word is the faulting address or the offending instruction bits. Only the register set of the destination level is updated. The other set keeps its contents.

Software reaches all six registers through a simple register port. A write takes effect at the next clock edge, and a read returns the current value in the same cycle. Neither the trap strobe nor the register port uses back-pressure. A trap is always accepted in the cycle it is strobed, and a register write is always accepted in the cycle `csr_wr_en` is high. For this reason no ready signal exists. Cause values are legalised before they are stored, so the cause registers only ever hold supported codes. PC values are aligned before they are stored, so they can never point at a misaligned instruction.

Top module: `trap_csr_bank`

## Requirements
- R1: After reset, all six registers read as zero.
- R2: A trap with `trap_to_sup`=0 writes the machine PC, cause and value registers at the next edge. The supervisor registers do not change.
- R3: A trap with `trap_to_sup`=1 writes the supervisor PC, cause and value registers at the next edge. The machine registers do not change.
- R4: The 3-bit register select works as follows. Bit 2 picks the level: 0 is machine, 1 is supervisor. Bits 1:0 pick the register: 0 is PC, 1 is cause, 2 is value. A write with `csr_wr_en` updates the selected register at the next edge.
- R5: A cause register reads with the interrupt flag in bit XLEN-1 and the code in bits 3:0. All other bits read as zero.
- R6: The only pairs that can be stored are supported ones. For exceptions these are codes 0–9, 11, 12, 13 and 15. For interrupts these are codes 1, 3, 5, 7, 9 and 11. Any other pair, including a software value with nonzero bits between bit 4 and bit XLEN-2, is stored as zero, with the flag and the code both cleared.
- R7: On an exception with code 0–7, 12, 13 or 15, the value register of the destination level is loaded with `trap_info`. Codes 0–7 cover misaligned, access fault, illegal instruction and breakpoint. Codes 12, 13 and 15 are page faults.
- R8: On an interrupt, or on any other exception code, the value register of the destination level is loaded with zero.
- R9: Bit 0 of a stored PC is always zero, whether written by a trap or by software. Bit 1 is also forced to zero when `c_ext_en` is low.
- R10: If a trap and a software write hit the same level in the same cycle, the trap values are stored. A software write to the other level still takes effect.
- R11: Reads are combinational. A select with bits 1:0 = 3 reads as zero, and a write to that select changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| c_ext_en | input | 1 | High when 16-bit instruction alignment is supported |
| trap_valid | input | 1 | Trap strobe, one cycle per trap |
| trap_to_sup | input | 1 | Destination level: 0 is machine, 1 is supervisor |
| trap_irq | input | 1 | Trap was caused by an interrupt |
| trap_code | input | 4 | Cause code |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_info | input | XLEN | Faulting address or instruction bits |
| csr_wr_en | input | 1 | Software write strobe |
| csr_wr_sel | input | 3 | Write register select |
| csr_wdata | input | XLEN | Software write data |
| csr_rd_sel | input | 3 | Read register select |
| csr_rdata | output | XLEN | Read data, same cycle |

## Verification
The assertions check several properties on every cycle. A register set that receives neither a trap nor a software write keeps its value. Bit 0 of a stored PC is never set. A trap always stores its own aligned PC, even when a software write to the same register arrives in that cycle. An interrupt trap always leaves a zero value register. Other properties are only shown by the bench scenarios, which compare every register against a behavioural model on every clock. These are whether the correct level was chosen, the legalisation of each cause code, the per-code choice between `trap_info` and zero, and the effect of the alignment input on bit 1.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

  localparam int unsigned CODE_W  = 4;
  localparam int unsigned N_LVL   = 2;

  // bit n set: code n is supported
  localparam logic [15:0] EXC_OK_MASK   = 16'hBBFF;
  localparam logic [15:0] IRQ_OK_MASK   = 16'h0AAA;
  // bit n set: exception code n records trap_info
  localparam logic [15:0] INFO_KEEP_MASK = 16'hB0FF;

  typedef enum logic [1:0] {
    FLD_EPC   = 2'd0,
    FLD_CAUSE = 2'd1,
    FLD_TVAL  = 2'd2,
    FLD_NONE  = 2'd3
  } fld_e;

endpackage

// File: rtl/trap_cause_legalize.sv
module trap_cause_legalize
  import trap_csr_pkg::*;
#(
  parameter int unsigned RAW_W = 31
) (
  input  logic              irq_i,
  input  logic [RAW_W-1:0]  code_i,
  output logic              irq_o,
  output logic [CODE_W-1:0] code_o
);

  logic              high_clear;
  logic [CODE_W-1:0] low_code;
  logic              supported;

  generate
    if (RAW_W > CODE_W) begin : g_wide
      assign high_clear = (code_i[RAW_W-1:CODE_W] == '0);
    end else begin : g_narrow
      assign high_clear = 1'b1;
    end
  endgenerate

  assign low_code = code_i[CODE_W-1:0];

  always_comb begin
    if (irq_i) supported = IRQ_OK_MASK[low_code];
    else       supported = EXC_OK_MASK[low_code];
    supported = supported & high_clear;
    irq_o  = supported ? irq_i    : 1'b0;
    code_o = supported ? low_code : '0;
  end

endmodule

// File: rtl/trap_tval_select.sv
module trap_tval_select
  import trap_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   info_i,
  output logic [XLEN-1:0]   tval_o
);

  logic keep;

  always_comb begin
    keep   = !irq_i && INFO_KEEP_MASK[code_i];
    tval_o = keep ? info_i : '0;
  end

endmodule

// File: rtl/trap_level_regs.sv
module trap_level_regs
  import trap_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_ext_en,
  input  logic              trap_hit,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              trap_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_tval,
  input  logic              sw_we,
  input  fld_e              sw_fld,
  input  logic [XLEN-1:0]   sw_wdata,
  input  logic              sw_irq,
  input  logic [CODE_W-1:0] sw_code,
  output logic [XLEN-1:0]   epc_q,
  output logic              irq_q,
  output logic [CODE_W-1:0] code_q,
  output logic [XLEN-1:0]   tval_q
);

  logic [XLEN-1:0] trap_pc_al;
  logic [XLEN-1:0] sw_pc_al;

  always_comb begin
    trap_pc_al    = trap_pc;
    trap_pc_al[0] = 1'b0;
    trap_pc_al[1] = trap_pc[1] & c_ext_en;
    sw_pc_al      = sw_wdata;
    sw_pc_al[0]   = 1'b0;
    sw_pc_al[1]   = sw_wdata[1] & c_ext_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q  <= '0;
      irq_q  <= 1'b0;
      code_q <= '0;
      tval_q <= '0;
    end else if (trap_hit) begin
      epc_q  <= trap_pc_al;
      irq_q  <= trap_irq;
      code_q <= trap_code;
      tval_q <= trap_tval;
    end else if (sw_we) begin
      unique case (sw_fld)
        FLD_EPC:   epc_q  <= sw_pc_al;
        FLD_CAUSE: begin
          irq_q  <= sw_irq;
          code_q <= sw_code;
        end
        FLD_TVAL:  tval_q <= sw_wdata;
        default:   ;
      endcase
    end
  end

  // R2 R3: a set left alone keeps its contents
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_hit && !sw_we) |=> ($stable(epc_q) && $stable(tval_q) && $stable(code_q) && $stable(irq_q)));

  // R9: the stored PC never has bit 0 set
  assert_pc_bit0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    epc_q[0] == 1'b0);

  // R10: a trap stores its own PC even when software writes in that cycle
  assert_trap_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> (epc_q[XLEN-1:2] == $past(trap_pc[XLEN-1:2])));

  // R8: an interrupt trap leaves a zero value register
  assert_irq_tval_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_hit && trap_irq) |=> (tval_q == '0));

endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
  import trap_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            c_ext_en,
  input  logic            trap_valid,
  input  logic            trap_to_sup,
  input  logic            trap_irq,
  input  logic [3:0]      trap_code,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [XLEN-1:0] trap_info,
  input  logic            csr_wr_en,
  input  logic [2:0]      csr_wr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [2:0]      csr_rd_sel,
  output logic [XLEN-1:0] csr_rdata
);

  localparam int unsigned PAD_W = XLEN - 1 - CODE_W;

  logic              t_irq_l;
  logic [CODE_W-1:0] t_code_l;
  logic [XLEN-1:0]   t_tval;
  logic              s_irq_l;
  logic [CODE_W-1:0] s_code_l;
  fld_e              wr_fld;

  logic [XLEN-1:0]   epc_arr  [N_LVL];
  logic              irq_arr  [N_LVL];
  logic [CODE_W-1:0] code_arr [N_LVL];
  logic [XLEN-1:0]   tval_arr [N_LVL];

  assign wr_fld = fld_e'(csr_wr_sel[1:0]);

  trap_cause_legalize #(.RAW_W(CODE_W)) u_trap_legal (
    .irq_i (trap_irq),
    .code_i(trap_code),
    .irq_o (t_irq_l),
    .code_o(t_code_l)
  );

  trap_cause_legalize #(.RAW_W(XLEN-1)) u_sw_legal (
    .irq_i (csr_wdata[XLEN-1]),
    .code_i(csr_wdata[XLEN-2:0]),
    .irq_o (s_irq_l),
    .code_o(s_code_l)
  );

  trap_tval_select #(.XLEN(XLEN)) u_tval_sel (
    .irq_i (trap_irq),
    .code_i(trap_code),
    .info_i(trap_info),
    .tval_o(t_tval)
  );

  generate
    for (genvar lv = 0; lv < N_LVL; lv++) begin : g_lvl
      logic hit;
      logic we;
      assign hit = trap_valid && (trap_to_sup == (lv == 1));
      assign we  = csr_wr_en && (csr_wr_sel[2] == (lv == 1)) && (wr_fld != FLD_NONE);

      trap_level_regs #(.XLEN(XLEN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .c_ext_en (c_ext_en),
        .trap_hit (hit),
        .trap_pc  (trap_pc),
        .trap_irq (t_irq_l),
        .trap_code(t_code_l),
        .trap_tval(t_tval),
        .sw_we    (we),
        .sw_fld   (wr_fld),
        .sw_wdata (csr_wdata),
        .sw_irq   (s_irq_l),
        .sw_code  (s_code_l),
        .epc_q    (epc_arr[lv]),
        .irq_q    (irq_arr[lv]),
        .code_q   (code_arr[lv]),
        .tval_q   (tval_arr[lv])
      );
    end
  endgenerate

  always_comb begin
    logic lsel;
    lsel = csr_rd_sel[2];
    unique case (fld_e'(csr_rd_sel[1:0]))
      FLD_EPC:   csr_rdata = epc_arr[lsel];
      FLD_CAUSE: csr_rdata = {irq_arr[lsel], {PAD_W{1'b0}}, code_arr[lsel]};
      FLD_TVAL:  csr_rdata = tval_arr[lsel];
      default:   csr_rdata = '0;
    endcase
  end

  // R11: an unmapped select always reads zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_sel[1:0] == 2'b11) |-> (csr_rdata == '0));

endmodule

// File: tb/tb_trap_csr_bank.sv
`timescale 1ns/100ps
module tb_trap_csr_bank;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            c_ext_en = 1'b1;
  logic            trap_valid = 1'b0;
  logic            trap_to_sup = 1'b0;
  logic            trap_irq = 1'b0;
  logic [3:0]      trap_code = '0;
  logic [XLEN-1:0] trap_pc = '0;
  logic [XLEN-1:0] trap_info = '0;
  logic            csr_wr_en = 1'b0;
  logic [2:0]      csr_wr_sel = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [2:0]      csr_rd_sel = '0;
  logic [XLEN-1:0] csr_rdata;

  int total = 0;
  int bad = 0;

  // model: index = level*4 + field
  logic [XLEN-1:0] mdl [8];

  always #2 clk = ~clk;

  trap_csr_bank #(.XLEN(XLEN)) dut (.*);

  function automatic logic [XLEN-1:0] legal_cause(input logic irq, input logic [XLEN-2:0] c);
    int exc_ok [$] = '{0,1,2,3,4,5,6,7,8,9,11,12,13,15};
    int irq_ok [$] = '{1,3,5,7,9,11};
    int hits [$];
    if (c > 15) return '0;
    if (irq) hits = irq_ok.find(x) with (x == int'(c));
    else     hits = exc_ok.find(x) with (x == int'(c));
    if (hits.size() == 0) return '0;
    return {irq, c};
  endfunction

  function automatic logic [XLEN-1:0] expect_tval(input logic irq, input int c, input logic [XLEN-1:0] info);
    int keep [$] = '{0,1,2,3,4,5,6,7,12,13,15};
    int hits [$];
    if (irq) return '0;
    hits = keep.find(x) with (x == c);
    return (hits.size() != 0) ? info : '0;
  endfunction

  function automatic logic [XLEN-1:0] align(input logic [XLEN-1:0] v, input logic cext);
    logic [XLEN-1:0] r;
    r = v;
    r[0] = 1'b0;
    if (!cext) r[1] = 1'b0;
    return r;
  endfunction

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp, input int sel);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", tag, sel, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    for (int s = 0; s < 8; s++) begin
      csr_rd_sel = 3'(s);
      #0.1;
      check(tag, csr_rdata, ((s % 4) == 3) ? '0 : mdl[s], s);
    end
  endtask

  // drive at negedge, advance the model at the edge, compare after it
  task automatic step(input string tag);
    logic [XLEN-1:0] nxt [8];
    int base;
    nxt = mdl;
    if (csr_wr_en && csr_wr_sel[1:0] != 2'b11) begin
      case (csr_wr_sel[1:0])
        2'd0: nxt[csr_wr_sel] = align(csr_wdata, c_ext_en);
        2'd1: nxt[csr_wr_sel] = legal_cause(csr_wdata[XLEN-1], csr_wdata[XLEN-2:0]);
        default: nxt[csr_wr_sel] = csr_wdata;
      endcase
    end
    if (trap_valid) begin
      base = trap_to_sup ? 4 : 0;
      nxt[base]   = align(trap_pc, c_ext_en);
      nxt[base+1] = legal_cause(trap_irq, (XLEN-1)'(trap_code));
      nxt[base+2] = expect_tval(trap_irq, int'(trap_code), trap_info);
    end
    @(posedge clk);
    mdl = nxt;
    #0.5;
    compare_all(tag);
    @(negedge clk);
    trap_valid = 1'b0;
    csr_wr_en  = 1'b0;
  endtask

  task automatic do_trap(input logic sup, input logic irq, input logic [3:0] code,
                         input logic [XLEN-1:0] pc, input logic [XLEN-1:0] info);
    trap_valid = 1'b1; trap_to_sup = sup; trap_irq = irq;
    trap_code = code; trap_pc = pc; trap_info = info;
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [XLEN-1:0] d);
    csr_wr_en = 1'b1; csr_wr_sel = sel; csr_wdata = d;
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    compare_all("R1 reset");
    @(negedge clk);

    do_trap(0, 0, 4'd5, 32'h0000_1004, 32'hDEAD_BEE0); step("R2 R7 machine load fault");
    do_trap(1, 1, 4'd5, 32'h0000_2002, 32'h1234_5678); step("R3 R5 R8 supervisor interrupt");
    do_trap(0, 0, 4'd8, 32'h0000_3000, 32'hFFFF_FFFF); step("R8 ecall value zero");
    do_trap(1, 0, 4'd2, 32'h0000_4000, 32'h0000_0073); step("R7 illegal instruction bits");
    do_trap(0, 0, 4'd15, 32'h0000_5006, 32'h8000_0000); step("R7 store page fault");
    do_trap(1, 0, 4'd10, 32'h0000_6000, 32'h1); step("R6 unsupported trap code");
    do_trap(0, 1, 4'd2, 32'h0000_6000, 32'h1); step("R6 unsupported interrupt code");

    do_write(3'd1, 32'h0000_000A); step("R6 software code 10");
    do_write(3'd5, 32'h8000_0002); step("R6 software interrupt code 2");
    do_write(3'd1, 32'h0000_0013); step("R6 software high code bits");
    do_write(3'd5, 32'h8000_000B); step("R4 R5 software interrupt 11");
    do_write(3'd6, 32'hCAFE_F00D); step("R4 supervisor value write");

    c_ext_en = 1'b0;
    do_write(3'd0, 32'h0000_7003); step("R9 software pc no 16-bit");
    do_trap(1, 0, 4'd0, 32'h0000_8006, 32'h0000_8006); step("R9 trap pc no 16-bit");
    c_ext_en = 1'b1;
    do_write(3'd4, 32'h0000_9007); step("R9 software pc 16-bit");

    do_trap(0, 0, 4'd3, 32'h0000_A000, 32'h0000_A010);
    do_write(3'd0, 32'h5555_5554); step("R10 trap beats same-level write");
    do_trap(0, 0, 4'd1, 32'h0000_B000, 32'h0000_B000);
    do_write(3'd6, 32'h0BAD_0000); step("R10 other level write still lands");

    do_write(3'd3, 32'hFFFF_FFFF); step("R11 unmapped write ignored");
    do_write(3'd7, 32'hFFFF_FFFF); step("R11 unmapped write ignored");

    for (int n = 0; n < 400; n++) begin
      c_ext_en = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 2) != 0)
        do_trap($urandom_range(0, 1), $urandom_range(0, 1), 4'($urandom_range(0, 15)),
                $urandom, $urandom);
      if ($urandom_range(0, 2) != 0) begin
        if ($urandom_range(0, 1) != 0)
          do_write(3'($urandom_range(0, 7)), {1'($urandom_range(0, 1)), 27'd0, 4'($urandom_range(0, 15))});
        else
          do_write(3'($urandom_range(0, 7)), $urandom);
      end
      step("R4 mixed traffic");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule